// File: doc/BRIEF.md
# Periodic Down-Count Tick Timer

This block is a 24-bit down-counter that software programs over a small 32-bit register bus. While it is enabled it counts toward zero. Each time it steps from one to zero it latches a sticky wrap flag and, if interrupts are allowed, sends a single-cycle pulse to the interrupt logic. On the next count step it restarts from a programmable reload value. This gives a periodic tick whose period is the reload value plus one count steps.

Counting is clocked by one of two sources. One is every cycle of the core clock. The other is a single-cycle reference tick enable that is synchronous to that clock. Software controls the timer through four word registers:

- a control/status word with enable, interrupt-allow, source-select and wrap-flag bits;
- the reload value;
- the live count;
- a fixed calibration word.

The bus carries a privilege marker. Unprivileged accesses are refused with an error response. Read data and the error response are registered and appear in the cycle after the access.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word, the reload value and the live count read zero, and `tick_irq` is low.
- R2: In the control word at offset 0x0, bit 0 is enable, bit 1 is interrupt-allow, bit 2 is source select and bit 16 is the wrap flag; all other bits read zero. A write updates only bits 2:0 and leaves the wrap flag unchanged.
- R3: With source select 0 the count changes only on cycles where `ref_tick` is high. With source select 1 it steps on every clock cycle.
- R4: The reload register at offset 0x4 stores the low 24 bits of the written data; the upper bits are discarded.
- R5: On a count step a nonzero count decrements by one, and a zero count loads the reload value. The period between wraps is therefore reload+1 steps.
- R6: A step from 1 to 0 sets the wrap flag. When interrupt-allow is 1, the same step raises `tick_irq` for exactly one cycle, in the cycle after the step; when it is 0 no pulse is produced.
- R7: A privileged read of the control word returns the wrap flag as it stood and then clears it.
- R8: Any write to the live count at offset 0x8 sets the count to zero and clears the wrap flag. The next step reloads; if the reload value is zero at the time of the write, counting stops instead.
- R9: A wrap that occurs while the reload value is zero stops counting, and the enable bit still reads 1. Counting resumes only after enable is written to 0 and then back to 1.
- R10: Offset 0xC always reads 10000 (0x2710), and writes to it are ignored.
- R11: An access with `bus_unpriv` high returns `bus_err` = 1 and read data 0 in the next cycle, and changes no register or flag. Privileged accesses return `bus_err` = 0.
- R12: Reads of any other offset return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write data |
| bus_unpriv | input | 1 | Access is unprivileged |
| bus_rdata | output | 32 | Read data, valid the cycle after the access |
| bus_err | output | 1 | Error response, valid the cycle after the access |
| ref_tick | input | 1 | Reference count enable, one cycle wide |
| tick_irq | output | 1 | One-cycle wrap interrupt pulse |

## Verification
The count is driven in two ways. In the first, the bench issues reference ticks one at a time, so each stage of load, decrement and wrap can be read back exactly. Reading the count after several idle core cycles shows that source 0 ignores the core clock. In the second, the timer runs from the core clock, and the spacing of interrupt pulses shows whether the period is reload+1 rather than reload. Separate runs with interrupts allowed and masked show whether the flag and the pulse are gated independently. A sequence that clears the reload while counting shows whether the timer stops at the wrap while the enable bit stays set. Writing the count with a zero reload shows whether a later nonzero reload is ignored.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int OFS_CTRL   = 'h0;
  localparam int OFS_RELOAD = 'h4;
  localparam int OFS_COUNT  = 'h8;
  localparam int OFS_CALIB  = 'hC;

  localparam int BIT_EN      = 0;
  localparam int BIT_IRQ_EN  = 1;
  localparam int BIT_SRC     = 2;
  localparam int BIT_FLAG    = 16;
  localparam int CTRL_WR_W   = 3;

  typedef struct packed {
    logic granted;
    logic wr_ctrl;
    logic wr_reload;
    logic wr_count;
    logic rd_ctrl;
    logic hit_ctrl;
    logic hit_reload;
    logic hit_count;
    logic hit_calib;
  } bus_strobe_t;

endpackage

// File: rtl/tt_bus_decode.sv
module tt_bus_decode
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              unpriv,
  output bus_strobe_t       stb
);

  logic ok;
  assign ok = sel & ~unpriv;

  always_comb begin
    stb            = '0;
    stb.granted    = ok;
    stb.hit_ctrl   = (addr == ADDR_W'(OFS_CTRL));
    stb.hit_reload = (addr == ADDR_W'(OFS_RELOAD));
    stb.hit_count  = (addr == ADDR_W'(OFS_COUNT));
    stb.hit_calib  = (addr == ADDR_W'(OFS_CALIB));
    stb.wr_ctrl    = ok & we & stb.hit_ctrl;
    stb.wr_reload  = ok & we & stb.hit_reload;
    stb.wr_count   = ok & we & stb.hit_count;
    stb.rd_ctrl    = ok & ~we & stb.hit_ctrl;
  end

endmodule

// File: rtl/tt_ctrl_reg.sv
module tt_ctrl_reg
  import tick_timer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [CTRL_WR_W-1:0] wbits,
  input  logic                 rd_clear,
  input  logic                 count_wr,
  input  logic                 wrap,
  output logic                 en_q,
  output logic                 irq_en_q,
  output logic                 src_q,
  output logic                 flag_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      irq_en_q <= 1'b0;
      src_q    <= 1'b0;
    end else if (wr) begin
      en_q     <= wbits[BIT_EN];
      irq_en_q <= wbits[BIT_IRQ_EN];
      src_q    <= wbits[BIT_SRC];
    end
  end

  // A wrap in the same cycle as a clearing read wins: the new event is kept.
  always_ff @(posedge clk) begin
    if (rst)                       flag_q <= 1'b0;
    else if (wrap)                 flag_q <= 1'b1;
    else if (rd_clear || count_wr) flag_q <= 1'b0;
  end

  p_flag_on_wrap_r6 : assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag_q);

  p_flag_cleared_r7 : assert property (@(posedge clk) disable iff (rst)
    ((rd_clear || count_wr) && !wrap) |=> !flag_q);

endmodule

// File: rtl/tt_down_counter.sv
module tt_down_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_core,
  input  logic             ref_tick,
  input  logic             en_toggle,
  input  logic             en_new,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] reload_wdata,
  input  logic             count_wr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] reload_q,
  output logic             wrap,
  output logic             run_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  logic reload_zero;

  assign step        = run_q & (src_core | ref_tick);
  assign reload_zero = (reload_q == '0);
  assign wrap        = step & ~count_wr & (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst)            reload_q <= '0;
    else if (reload_wr) reload_q <= reload_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (count_wr) cnt_q <= '0;
    else if (step)     cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)                           run_q <= 1'b0;
    else if (count_wr && reload_zero)  run_q <= 1'b0;
    else if (en_toggle)                run_q <= en_new;
    else if (wrap && reload_zero)      run_q <= 1'b0;
  end

  p_idle_hold_r9 : assert property (@(posedge clk) disable iff (rst)
    (!run_q && !count_wr) |=> $stable(cnt_q));

  p_zero_reload_halt_r9 : assert property (@(posedge clk) disable iff (rst)
    (wrap && reload_zero && !en_toggle) |=> !run_q);

  p_count_write_zero_r8 : assert property (@(posedge clk) disable iff (rst)
    count_wr |=> (cnt_q == '0));

  p_reload_store_r4 : assert property (@(posedge clk) disable iff (rst)
    reload_wr |=> (reload_q == $past(reload_wdata)));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 24,
  parameter int CAL_VALUE = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_unpriv,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              ref_tick,
  output logic              tick_irq
);

  localparam logic [DATA_W-1:0] CAL_WORD = DATA_W'(CAL_VALUE);

  bus_strobe_t       stb;
  logic              en_q, irq_en_q, src_q, flag_q;
  logic [CNT_W-1:0]  cnt_q, reload_q;
  logic              wrap, run_q;
  logic              en_toggle;
  logic [DATA_W-1:0] ctrl_word, rd_word;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

  tt_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
    .sel    (bus_sel),
    .addr   (bus_addr),
    .we     (bus_we),
    .unpriv (bus_unpriv),
    .stb    (stb)
  );

  assign en_toggle = stb.wr_ctrl & (bus_wdata[BIT_EN] != en_q);

  tt_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr       (stb.wr_ctrl),
    .wbits    (bus_wdata[CTRL_WR_W-1:0]),
    .rd_clear (stb.rd_ctrl),
    .count_wr (stb.wr_count),
    .wrap     (wrap),
    .en_q     (en_q),
    .irq_en_q (irq_en_q),
    .src_q    (src_q),
    .flag_q   (flag_q)
  );

  tt_down_counter #(.CNT_W(CNT_W)) u_count (
    .clk          (clk),
    .rst          (rst),
    .src_core     (src_q),
    .ref_tick     (ref_tick),
    .en_toggle    (en_toggle),
    .en_new       (bus_wdata[BIT_EN]),
    .reload_wr    (stb.wr_reload),
    .reload_wdata (bus_wdata[CNT_W-1:0]),
    .count_wr     (stb.wr_count),
    .cnt_q        (cnt_q),
    .reload_q     (reload_q),
    .wrap         (wrap),
    .run_q        (run_q)
  );

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[BIT_EN]      = en_q;
    ctrl_word[BIT_IRQ_EN]  = irq_en_q;
    ctrl_word[BIT_SRC]     = src_q;
    ctrl_word[BIT_FLAG]    = flag_q;
  end

  always_comb begin
    rd_word = '0;
    if (stb.hit_ctrl)   rd_word = ctrl_word;
    if (stb.hit_reload) rd_word = DATA_W'(reload_q);
    if (stb.hit_count)  rd_word = DATA_W'(cnt_q);
    if (stb.hit_calib)  rd_word = CAL_WORD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      tick_irq  <= 1'b0;
    end else begin
      bus_err   <= bus_sel & bus_unpriv;
      bus_rdata <= (stb.granted && !bus_we) ? rd_word : '0;
      tick_irq  <= wrap & irq_en_q;
    end
  end

  p_irq_single_r6 : assert property (@(posedge clk) disable iff (rst)
    tick_irq |=> !tick_irq);

  p_unpriv_refused_r11 : assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_unpriv) |=> (bus_err && bus_rdata == '0));

  p_calib_const_r10 : assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_unpriv && !bus_we && bus_addr == ADDR_W'(OFS_CALIB))
      |=> (bus_rdata == CAL_WORD));

  p_unpriv_no_effect_r11 : assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_unpriv) |=> $stable(reload_q));

endmodule

// File: tb/test_tick_timer.sv
`timescale 1ns/1ps
module test_tick_timer;

  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_TK = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic        unpriv;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        exp_err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS [NV] = '{
    '{K_RD, 1'b0, 8'h00, 32'h0,        32'h0,     1'b0, 4'd1},  // R1
    '{K_RD, 1'b0, 8'h04, 32'h0,        32'h0,     1'b0, 4'd1},  // R1
    '{K_RD, 1'b0, 8'h08, 32'h0,        32'h0,     1'b0, 4'd1},  // R1
    '{K_WR, 1'b0, 8'h04, 32'hFF000005, 32'h0,     1'b0, 4'd4},  // R4
    '{K_RD, 1'b0, 8'h04, 32'h0,        32'h5,     1'b0, 4'd4},  // R4
    '{K_WR, 1'b0, 8'h00, 32'hFFFFFFFB, 32'h0,     1'b0, 4'd2},  // R2
    '{K_RD, 1'b0, 8'h00, 32'h0,        32'h3,     1'b0, 4'd2},  // R2
    '{K_TK, 1'b0, 8'h00, 32'd1,        32'h0,     1'b0, 4'd5},  // R5 load
    '{K_RD, 1'b0, 8'h08, 32'h0,        32'h5,     1'b0, 4'd5},  // R5
    '{K_TK, 1'b0, 8'h00, 32'd3,        32'h0,     1'b0, 4'd3},  // R3
    '{K_RD, 1'b0, 8'h08, 32'h0,        32'h2,     1'b0, 4'd3},  // R3
    '{K_TK, 1'b0, 8'h00, 32'd2,        32'h0,     1'b0, 4'd6},  // R6 wrap
    '{K_WR, 1'b0, 8'h00, 32'h3,        32'h0,     1'b0, 4'd2},  // R2 flag kept
    '{K_RD, 1'b0, 8'h00, 32'h0,        32'h10003, 1'b0, 4'd6},  // R6
    '{K_RD, 1'b0, 8'h00, 32'h0,        32'h3,     1'b0, 4'd7},  // R7
    '{K_TK, 1'b0, 8'h00, 32'd1,        32'h0,     1'b0, 4'd5},  // R5
    '{K_RD, 1'b0, 8'h08, 32'h0,        32'h5,     1'b0, 4'd5},  // R5
    '{K_WR, 1'b0, 8'h08, 32'h7B,       32'h0,     1'b0, 4'd8},  // R8
    '{K_RD, 1'b0, 8'h08, 32'h0,        32'h0,     1'b0, 4'd8},  // R8
    '{K_TK, 1'b0, 8'h00, 32'd1,        32'h0,     1'b0, 4'd8},  // R8
    '{K_RD, 1'b0, 8'h08, 32'h0,        32'h5,     1'b0, 4'd8},  // R8
    '{K_RD, 1'b0, 8'h0C, 32'h0,        32'h2710,  1'b0, 4'd10}, // R10
    '{K_WR, 1'b0, 8'h0C, 32'h0,        32'h0,     1'b0, 4'd10}, // R10
    '{K_RD, 1'b0, 8'h0C, 32'h0,        32'h2710,  1'b0, 4'd10}, // R10
    '{K_RD, 1'b1, 8'h00, 32'h0,        32'h0,     1'b1, 4'd11}, // R11
    '{K_WR, 1'b1, 8'h04, 32'h7,        32'h0,     1'b0, 4'd11}, // R11
    '{K_RD, 1'b0, 8'h04, 32'h0,        32'h5,     1'b0, 4'd11}, // R11
    '{K_WR, 1'b1, 8'h08, 32'h0,        32'h0,     1'b0, 4'd11}, // R11
    '{K_RD, 1'b0, 8'h08, 32'h0,        32'h5,     1'b0, 4'd11}, // R11
    '{K_RD, 1'b0, 8'h10, 32'h0,        32'h0,     1'b0, 4'd12}, // R12
    '{K_WR, 1'b0, 8'h10, 32'hFFFFFFFF, 32'h0,     1'b0, 4'd12}, // R12
    '{K_RD, 1'b0, 8'h04, 32'h0,        32'h5,     1'b0, 4'd12}, // R12
    '{K_RD, 1'b0, 8'h08, 32'h0,        32'h5,     1'b0, 4'd12}, // R12
    '{K_RD, 1'b0, 8'h00, 32'h0,        32'h3,     1'b0, 4'd12}, // R12
    '{K_RD, 1'b0, 8'hE0, 32'h0,        32'h0,     1'b0, 4'd12}  // R12
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0, bus_unpriv = 1'b0, ref_tick = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, tick_irq;

  int tests = 0, fails = 0;
  int cyc = 0, irq_count = 0, last_irq = 0, prev_irq = 0;
  logic irq_prev = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tick_timer i_tick_timer (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_unpriv(bus_unpriv), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .ref_tick(ref_tick), .tick_irq(tick_irq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // R6: pulse accounting and single-cycle width
  always @(negedge clk) begin
    if (!rst && tick_irq) begin
      irq_count = irq_count + 1;
      prev_irq  = last_irq;
      last_irq  = cyc;
      if (irq_prev) begin
        tests = tests + 1; fails = fails + 1;
        $display("FAIL R6 irq width: high in two cycles, act=2 exp=1");
      end
    end
    irq_prev = tick_irq;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic up);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_unpriv = up;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_unpriv = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic up, output logic [31:0] d,
                    output logic e);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_unpriv = up;
    @(negedge clk);
    d = bus_rdata; e = bus_err;
    bus_sel = 1'b0; bus_unpriv = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d; logic e;
    rd(a, 1'b0, d, e);
    check(d == exp && !e, req, d, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests = tests + 1; fails = fails + 1;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; logic e; int c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(tick_irq == 1'b0, "R1 irq after reset", 32'(tick_irq), 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].kind)
        K_WR: wr(VECS[i].addr, VECS[i].data, VECS[i].unpriv);
        K_TK: ticks(int'(VECS[i].data));
        default: begin
          rd(VECS[i].addr, VECS[i].unpriv, d, e);
          tests = tests + 1;
          if (d !== VECS[i].exp || e !== VECS[i].exp_err) begin
            fails = fails + 1;
            $display("FAIL R%0d vec %0d act=0x%0h/err%0b exp=0x%0h/err%0b",
                     VECS[i].req, i, d, e, VECS[i].exp, VECS[i].exp_err);
          end
        end
      endcase
    end
    check(irq_count == 1, "R6 pulse count in table", 32'(irq_count), 32'd1);

    // R5/R3: core-clock source, period reload+1
    wr(8'h00, 32'h0, 1'b0);
    wr(8'h04, 32'd3, 1'b0);
    wr(8'h08, 32'h0, 1'b0);
    wr(8'h00, 32'h7, 1'b0);
    repeat (30) @(negedge clk);
    check(last_irq - prev_irq == 4, "R5 period", 32'(last_irq - prev_irq), 32'd4);
    check(irq_count >= 6, "R3 core source counts", 32'(irq_count), 32'd6);

    // R6: interrupt masked, flag still set
    wr(8'h00, 32'h5, 1'b0);
    @(negedge clk); #1;
    c0 = irq_count;
    repeat (20) @(negedge clk);
    check(irq_count == c0, "R6 masked irq", 32'(irq_count), 32'(c0));
    rd_chk(8'h00, 32'h10005, "R6 flag when masked");

    // R9: zero reload halts at wrap, enable stays set
    wr(8'h00, 32'h0, 1'b0);
    wr(8'h04, 32'd2, 1'b0);
    wr(8'h08, 32'h0, 1'b0);
    wr(8'h00, 32'h1, 1'b0);
    ticks(1);
    wr(8'h04, 32'h0, 1'b0);
    ticks(2);
    rd_chk(8'h08, 32'h0, "R9 count at halt");
    wr(8'h04, 32'd4, 1'b0);
    ticks(3);
    rd_chk(8'h08, 32'h0, "R9 stays halted");
    rd_chk(8'h00, 32'h10001, "R9 enable kept");
    wr(8'h00, 32'h0, 1'b0);
    wr(8'h00, 32'h1, 1'b0);
    ticks(1);
    rd_chk(8'h08, 32'h4, "R9 restart");

    // R8: count write with zero reload stops
    wr(8'h04, 32'h0, 1'b0);
    wr(8'h08, 32'h0, 1'b0);
    wr(8'h04, 32'd3, 1'b0);
    ticks(2);
    rd_chk(8'h08, 32'h0, "R8 stopped by write");
    rd_chk(8'h00, 32'h1, "R8 flag cleared");

    // R1: reset mid-run
    wr(8'h04, 32'd9, 1'b0);
    wr(8'h00, 32'h7, 1'b0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check(tick_irq == 1'b0, "R1 irq low", 32'(tick_irq), 32'h0);
    rd_chk(8'h00, 32'h0, "R1 ctrl");
    rd_chk(8'h04, 32'h0, "R1 reload");
    rd_chk(8'h08, 32'h0, "R1 count");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule